// File: doc/BRIEF.md
# SPI Buffer Ownership Semaphore

This block decides who may touch a buffer that is shared between a processor and an SPI slave shifting engine. The processor sends one-cycle acquire and release requests. The SPI engine reports two things: that its chip select has gone active, and that a granted transaction has finished. The block holds a two-bit owner code that software can read. It grants the buffer to the SPI engine only while the engine owns it.

A processor request that arrives while the SPI side owns the buffer is not lost. It is parked, and the buffer passes to the processor as soon as the running transaction finishes. An optional auto-reacquire input gives the buffer back to the processor whenever a transaction finishes, with no separate request needed.

Two events are kept: "processor gained the buffer" and "SPI transaction finished". Each event drives a one-cycle pulse and a sticky flag. A flag asserts the interrupt line when its enable is also set.

Top module: `spi_buf_semaphore`

## Requirements
- R1: After reset `state_o` is 0, and `grant_o`, `acquired_o`, `end_o`, `flags_o` and `irq_o` are all 0. All interrupt enables are cleared.
- R2: The owner codes are 0 = free, 1 = processor, 2 = SPI engine, 3 = SPI engine with a processor request waiting. An acquire while the code is 0 makes it 1 at the next clock edge, and `acquired_o` is high for exactly that one cycle.
- R3: A release while the code is 1 makes it 0 at the next edge. A release in any other code changes nothing.
- R4: Chip select active while the code is 0 makes it 2 and raises `grant_o`. Chip select while the processor owns the buffer (code 1) leaves the code at 1 and `grant_o` low.
- R5: An acquire while the code is 2 makes it 3, and `grant_o` stays high. A transaction end while the code is 3 makes it 1 and pulses `acquired_o`.
- R6: A transaction end while the code is 2, with no acquire and no auto-reacquire, makes it 0. `end_o` pulses for a transaction end only when the code was 2 or 3. A transaction end in code 0 or 1 has no effect.
- R7: With `auto_reacq_i` high, a transaction end while the code is 2 makes it 1 and pulses `acquired_o`.
- R8: When acquire and chip select arrive together in code 0, the parameter `CPU_FIRST` settles the tie. With the default `CPU_FIRST=1` the result is code 1 with an `acquired_o` pulse. With `CPU_FIRST=0` the result is code 3.
- R9: Bit 0 of `flags_o` is the acquired event and bit 1 is the transaction-end event. A flag becomes 1 in the same cycle as its pulse. It stays 1 until the matching `flag_clr_i` bit is strobed. An event in the same cycle as a clear leaves the flag set.
- R10: `ien_set_i` bits set interrupt enables and `ien_clr_i` bits clear them, using the same bit order as the flags, with set winning over clear. `irq_o` is high exactly when some flag and its enable are both 1.
- R11: An acquire while the code is 1 or 3 changes nothing and produces no `acquired_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acquire_i | input | 1 | Processor acquire request, one-cycle pulse |
| release_i | input | 1 | Processor release request, one-cycle pulse |
| cs_active_i | input | 1 | SPI engine reports chip select active |
| xfer_end_i | input | 1 | SPI engine reports transaction finished |
| auto_reacq_i | input | 1 | Hand buffer back to processor on every transaction end |
| flag_clr_i | input | 2 | Per-event sticky flag clear strobes |
| ien_set_i | input | 2 | Interrupt enable set mask |
| ien_clr_i | input | 2 | Interrupt enable clear mask |
| state_o | output | 2 | Owner code |
| grant_o | output | 1 | SPI engine owns the buffer |
| acquired_o | output | 1 | One-cycle pulse: processor gained the buffer |
| end_o | output | 1 | One-cycle pulse: granted transaction finished |
| flags_o | output | 2 | Sticky event flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default `CPU_FIRST=1`. With that setting, the simultaneous acquire and chip-select case resolves in the processor's favour, and the bench's own model predicts that outcome. Walking through every owner code with every request type covers all handover paths: the parked request, the auto-reacquire path, and each ignored request. It also shows how the sticky flags and the enables interact with the clear and set masks in the same cycle.

// File: rtl/sem_pkg.sv
package sem_pkg;

  localparam int OWN_W = 2;
  localparam int EVT_N = 2;
  localparam int EVT_ACQ = 0;
  localparam int EVT_END = 1;

  typedef enum logic [OWN_W-1:0] {
    OWN_FREE     = 2'd0,
    OWN_CPU      = 2'd1,
    OWN_SPI      = 2'd2,
    OWN_SPI_WAIT = 2'd3
  } own_t;

  // Next owner from the current owner and this cycle's requests.
  function automatic own_t own_next(own_t cur, logic acq, logic rel, logic cs,
                                    logic done, logic auto_re, logic cpu_first);
    own_t nxt;
    nxt = cur;
    case (cur)
      OWN_FREE: begin
        if (acq && cs) nxt = cpu_first ? OWN_CPU : OWN_SPI_WAIT;
        else if (acq)  nxt = OWN_CPU;
        else if (cs)   nxt = OWN_SPI;
      end
      OWN_CPU: begin
        if (rel) nxt = OWN_FREE;
      end
      OWN_SPI: begin
        if (done)     nxt = (acq || auto_re) ? OWN_CPU : OWN_FREE;
        else if (acq) nxt = OWN_SPI_WAIT;
      end
      OWN_SPI_WAIT: begin
        if (done) nxt = OWN_CPU;
      end
      default: nxt = OWN_FREE;
    endcase
    return nxt;
  endfunction

  // Processor gains the buffer on this transition.
  function automatic logic gains_cpu(own_t cur, own_t nxt);
    return (cur != OWN_CPU) && (nxt == OWN_CPU);
  endfunction

  // A transaction end counts only while the SPI side holds the buffer.
  function automatic logic spi_owned(own_t cur);
    return (cur == OWN_SPI) || (cur == OWN_SPI_WAIT);
  endfunction

endpackage

// File: rtl/sem_owner_fsm.sv
module sem_owner_fsm
  import sem_pkg::*;
#(
  parameter bit CPU_FIRST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acquire_i,
  input  logic release_i,
  input  logic cs_active_i,
  input  logic xfer_end_i,
  input  logic auto_reacq_i,
  output own_t owner_o,
  output logic acq_evt_o,
  output logic end_evt_o,
  output logic acq_pulse_o,
  output logic end_pulse_o
);

  own_t owner_q;
  own_t owner_d;

  always_comb begin
    owner_d   = own_next(owner_q, acquire_i, release_i, cs_active_i,
                         xfer_end_i, auto_reacq_i, CPU_FIRST);
    acq_evt_o = gains_cpu(owner_q, owner_d);
    end_evt_o = xfer_end_i && spi_owned(owner_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q     <= OWN_FREE;
      acq_pulse_o <= 1'b0;
      end_pulse_o <= 1'b0;
    end else begin
      owner_q     <= owner_d;
      acq_pulse_o <= acq_evt_o;
      end_pulse_o <= end_evt_o;
    end
  end

  assign owner_o = owner_q;

endmodule

// File: rtl/sem_event_bank.sv
module sem_event_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_set_i,
  input  logic [N-1:0] en_clr_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);

  for (genvar g = 0; g < N; g++) begin : g_evt
    logic flag_q;
    logic en_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
        en_q   <= 1'b0;
      end else begin
        flag_q <= evt_i[g] | (flag_q & ~clr_i[g]);
        en_q   <= en_set_i[g] | (en_q & ~en_clr_i[g]);
      end
    end
    assign flags_o[g] = flag_q;
    assign en_o[g]    = en_q;
  end

  assign irq_o = |(flags_o & en_o);

endmodule

// File: rtl/spi_buf_semaphore.sv
module spi_buf_semaphore
  import sem_pkg::*;
#(
  parameter bit CPU_FIRST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acquire_i,
  input  logic             release_i,
  input  logic             cs_active_i,
  input  logic             xfer_end_i,
  input  logic             auto_reacq_i,
  input  logic [EVT_N-1:0] flag_clr_i,
  input  logic [EVT_N-1:0] ien_set_i,
  input  logic [EVT_N-1:0] ien_clr_i,
  output logic [OWN_W-1:0] state_o,
  output logic             grant_o,
  output logic             acquired_o,
  output logic             end_o,
  output logic [EVT_N-1:0] flags_o,
  output logic             irq_o
);

  own_t             owner;
  logic             acq_evt;
  logic             end_evt;
  logic [EVT_N-1:0] evt_vec;
  logic [EVT_N-1:0] ien;

  sem_owner_fsm #(.CPU_FIRST(CPU_FIRST)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .acquire_i   (acquire_i),
    .release_i   (release_i),
    .cs_active_i (cs_active_i),
    .xfer_end_i  (xfer_end_i),
    .auto_reacq_i(auto_reacq_i),
    .owner_o     (owner),
    .acq_evt_o   (acq_evt),
    .end_evt_o   (end_evt),
    .acq_pulse_o (acquired_o),
    .end_pulse_o (end_o)
  );

  always_comb begin
    evt_vec          = '0;
    evt_vec[EVT_ACQ] = acq_evt;
    evt_vec[EVT_END] = end_evt;
  end

  sem_event_bank #(.N(EVT_N)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_vec),
    .clr_i   (flag_clr_i),
    .en_set_i(ien_set_i),
    .en_clr_i(ien_clr_i),
    .flags_o (flags_o),
    .en_o    (ien),
    .irq_o   (irq_o)
  );

  assign state_o = owner;
  assign grant_o = spi_owned(owner);

endmodule

// File: rtl/sem_checker.sv
module sem_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       acquire_i,
  input logic       release_i,
  input logic       cs_active_i,
  input logic       xfer_end_i,
  input logic       auto_reacq_i,
  input logic [1:0] state_o,
  input logic       grant_o,
  input logic       acquired_o,
  input logic       end_o,
  input logic [1:0] flags_o
);

  assert_free_acquire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && acquire_i) |=> (state_o == 2'd1 && acquired_o));

  assert_acq_pulse_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acquired_o |-> state_o == 2'd1);

  assert_release_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && release_i) |=> state_o == 2'd0);

  assert_cs_grants_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && cs_active_i && !acquire_i) |=> (state_o == 2'd2 && grant_o));

  assert_wait_handover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3 && xfer_end_i) |=> (state_o == 2'd1 && acquired_o));

  assert_end_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && xfer_end_i && !acquire_i && !auto_reacq_i) |=> (state_o == 2'd0 && end_o));

  assert_auto_reacq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && xfer_end_i && auto_reacq_i) |=> (state_o == 2'd1 && acquired_o));

  assert_flag_follows_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acquired_o |-> flags_o[0]) and (end_o |-> flags_o[1]));

  assert_cpu_acquire_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && !release_i) |=> (state_o == 2'd1 && !acquired_o));

endmodule

bind spi_buf_semaphore sem_checker i_sem_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .acquire_i   (acquire_i),
  .release_i   (release_i),
  .cs_active_i (cs_active_i),
  .xfer_end_i  (xfer_end_i),
  .auto_reacq_i(auto_reacq_i),
  .state_o     (state_o),
  .grant_o     (grant_o),
  .acquired_o  (acquired_o),
  .end_o       (end_o),
  .flags_o     (flags_o)
);

// File: tb/test_spi_buf_semaphore.sv
`timescale 1ns/1ps
module test_spi_buf_semaphore;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acquire_i = 0, release_i = 0, cs_active_i = 0, xfer_end_i = 0, auto_reacq_i = 0;
  logic [1:0] flag_clr_i = 0, ien_set_i = 0, ien_clr_i = 0;
  logic [1:0] state_o;
  logic       grant_o, acquired_o, end_o, irq_o;
  logic [1:0] flags_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  spi_buf_semaphore i_spi_buf_semaphore (
    .clk(clk), .rst_n(rst_n), .acquire_i(acquire_i), .release_i(release_i),
    .cs_active_i(cs_active_i), .xfer_end_i(xfer_end_i), .auto_reacq_i(auto_reacq_i),
    .flag_clr_i(flag_clr_i), .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i),
    .state_o(state_o), .grant_o(grant_o), .acquired_o(acquired_o), .end_o(end_o),
    .flags_o(flags_o), .irq_o(irq_o)
  );

  typedef struct {
    logic [7:0] packed_out;  // {state,grant,acq,end,flags,irq}
    string      tag;
  } exp_t;

  exp_t scb[$];

  // Bench-side model state
  logic [1:0] m_own = 2'd0;
  logic [1:0] m_flg = 2'd0;
  logic [1:0] m_ien = 2'd0;

  function automatic logic [7:0] pack_out(logic [1:0] s, logic g, logic a, logic e,
                                          logic [1:0] f, logic i);
    return {s, g, a, e, f, i};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b (state,grant,acq,end,flags,irq)", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the predicted outputs.
  task automatic step(string tag, logic a, logic r, logic cs, logic d, logic au,
                      logic [1:0] fc, logic [1:0] es, logic [1:0] ec);
    logic [1:0] nx;
    logic       ga, ge;
    exp_t       it;
    @(negedge clk);
    acquire_i = a; release_i = r; cs_active_i = cs; xfer_end_i = d; auto_reacq_i = au;
    flag_clr_i = fc; ien_set_i = es; ien_clr_i = ec;
    nx = m_own;
    if (m_own == 2'd0) begin
      if (a) nx = 2'd1;           // processor first on a tie (default build)
      else if (cs) nx = 2'd2;
    end else if (m_own == 2'd1) begin
      if (r) nx = 2'd0;
    end else if (m_own == 2'd2) begin
      if (d && (a || au)) nx = 2'd1;
      else if (d) nx = 2'd0;
      else if (a) nx = 2'd3;
    end else begin
      if (d) nx = 2'd1;
    end
    ga = (nx == 2'd1) && (m_own != 2'd1);
    ge = d && m_own[1];
    m_flg = {ge, ga} | (m_flg & ~fc);
    m_ien = es | (m_ien & ~ec);
    m_own = nx;
    it.packed_out = pack_out(m_own, m_own[1], ga, ge, m_flg, |(m_flg & m_ien));
    it.tag = tag;
    scb.push_back(it);
  endtask

  // Monitor: compares after each rising edge.
  always @(posedge clk) begin
    #1;
    if (scb.size() > 0) begin
      exp_t it;
      it = scb.pop_front();
      check(it.tag, pack_out(state_o, grant_o, acquired_o, end_o, flags_o, irq_o), it.packed_out);
    end
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", pack_out(state_o, grant_o, acquired_o, end_o, flags_o, irq_o), 8'd0);
    rst_n = 1'b1;
    //        tag                         a r cs d au fc    es    ec
    step("R2 acquire from free",          1,0,0, 0,0, 2'b00,2'b00,2'b00);
    step("R2 pulse single cycle",         0,0,0, 0,0, 2'b00,2'b00,2'b00);
    step("R11 acquire while cpu",         1,0,0, 0,0, 2'b00,2'b00,2'b00);
    step("R4 cs while cpu ignored",       0,0,1, 0,0, 2'b00,2'b00,2'b00);
    step("R6 end while cpu ignored",      0,0,0, 1,0, 2'b00,2'b00,2'b00);
    step("R3 release from cpu",           0,1,0, 0,0, 2'b00,2'b00,2'b00);
    step("R3 release while free",         0,1,0, 0,0, 2'b00,2'b00,2'b00);
    step("R6 end while free ignored",     0,0,0, 1,0, 2'b00,2'b00,2'b00);
    step("R4 cs grants spi",              0,0,1, 0,0, 2'b00,2'b00,2'b00);
    step("R3 release while spi",          0,1,0, 0,0, 2'b00,2'b00,2'b00);
    step("R5 acquire parks request",      1,0,0, 0,0, 2'b00,2'b00,2'b00);
    step("R11 acquire while waiting",     1,0,0, 0,0, 2'b00,2'b00,2'b00);
    step("R3 release while waiting",      0,1,0, 0,0, 2'b00,2'b00,2'b00);
    step("R5 end hands over",             0,0,0, 1,0, 2'b00,2'b00,2'b00);
    step("R10 enable acquired irq",       0,0,0, 0,0, 2'b00,2'b01,2'b00);
    step("R9 clear acquired flag",        0,0,0, 0,0, 2'b01,2'b00,2'b00);
    step("R3 release again",              0,1,0, 0,0, 2'b00,2'b00,2'b00);
    step("R4 cs grants spi",              0,0,1, 0,0, 2'b00,2'b00,2'b00);
    step("R6 end frees buffer",           0,0,0, 1,0, 2'b00,2'b00,2'b00);
    step("R10 enable end irq",            0,0,0, 0,0, 2'b00,2'b10,2'b00);
    step("R10 set wins over clear",       0,0,0, 0,0, 2'b00,2'b10,2'b10);
    step("R10 clear end enable",          0,0,0, 0,0, 2'b00,2'b00,2'b10);
    step("R9 flag sticky",                0,0,0, 0,0, 2'b00,2'b00,2'b00);
    step("R4 cs grants spi",              0,0,1, 0,0, 2'b10,2'b00,2'b00);
    step("R7 auto reacquire",             0,0,0, 1,1, 2'b11,2'b00,2'b00);
    step("R9 event beats clear",          0,0,0, 0,0, 2'b00,2'b00,2'b00);
    step("R3 release",                    0,1,0, 0,0, 2'b11,2'b00,2'b00);
    step("R8 tie favours cpu",            1,0,1, 0,0, 2'b00,2'b00,2'b00);
    step("R3 release",                    0,1,0, 0,0, 2'b00,2'b00,2'b11);
    step("R4 cs grants spi",              0,0,1, 0,0, 2'b00,2'b00,2'b00);
    step("R6 end with acquire to cpu",    1,0,0, 1,0, 2'b00,2'b00,2'b00);
    step("R2 idle after handover",        0,0,0, 0,0, 2'b00,2'b00,2'b00);
    @(negedge clk);
    acquire_i = 0; release_i = 0; cs_active_i = 0; xfer_end_i = 0; auto_reacq_i = 0;
    flag_clr_i = 0; ien_set_i = 0; ien_clr_i = 0;
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule